// File: doc/BRIEF.md
# Mixed-Width Dual-Port Synchronous RAM

This block is a synchronous random-access memory with two fully independent access ports, A and B, which share one clock. Each port has its own address, write data, write enable, read enable and registered read data. Every port can read or write any location in any cycle, whatever the other port is doing.

The two ports can be built with different data widths over the same storage. The storage is organised as rows of `WIDE_SLICES` slices, each `SLICE_W` bits wide. A port whose width is `RATIO` slices sees `WIDE_SLICES/RATIO` words per row. Its low address bits pick the word inside the row, and the lowest such address sits in the least significant bits. A slice width of 8 gives the ×8/×16/×32 family. A slice width of 9 gives the ×9/×18/×36 family, which carries parity bits.

A parameter chooses what a port returns when it reads and writes the same location on one edge: new data or old data. A second parameter adds an output register stage. The block does not arbitrate simultaneous writes from both ports. It raises a one-cycle flag when such writes touch overlapping slices, and the contents of those slices are then undefined.

Top module: `mtdp_ram`

## Requirements
- R1: While reset is asserted and right after it, both read data outputs and the collision flag are zero.
- R2: The narrow-port address is {row, lane}, with the lane in the low bits. A narrow word at lane k occupies bits [k*W_narrow +: W_narrow] of the row, so lane 0 is the least significant.
- R3: With `OUT_REG`=0, a read with its enable high at one clock edge shows the stored word on that port's read data after that edge. This holds on either port, at any address.
- R4: While a port's read enable is low, its read data does not change, including while that port writes.
- R5: With `RDW_MODE`=RDW_NEW, a port that reads and writes one address on the same edge returns the data it is writing.
- R6: With `RDW_MODE`=RDW_OLD, a port that reads and writes one address on the same edge returns the contents from before the write.
- R7: When one port reads a location that the other port writes on the same edge, it returns the contents from before the write.
- R8: With `OUT_REG`=1, read data appears exactly one cycle later than with `OUT_REG`=0, and the value is the same.
- R9: The collision flag is high during the cycle after an edge where both ports write overlapping slices of one row. It is low after any edge without two writes.
- R10: With `SLICE_W`=9, a wide write is read back intact through the 9-bit narrow port.
- R11: A narrow write changes only its own slices. The rest of the row keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset for the output registers and the flag |
| addr_a | input | AW_A | Port A address |
| wdata_a | input | DW_A | Port A write data |
| we_a | input | 1 | Port A write enable |
| re_a | input | 1 | Port A read enable |
| rdata_a | output | DW_A | Port A read data |
| addr_b | input | AW_B | Port B address |
| wdata_b | input | DW_B | Port B write data |
| we_b | input | 1 | Port B write enable |
| re_b | input | 1 | Port B read enable |
| rdata_b | output | DW_B | Port B read data |
| collision | output | 1 | Overlapping simultaneous writes seen on the previous edge |

## Verification
The embedded properties check the following in every cycle:
- the read register holds while its enable is low;
- the extra output stage adds exactly one cycle of delay;
- a same-port write-plus-read in new-data mode returns the written word;
- the collision flag stays low unless both ports wrote the same row.

Only the bench scenarios can show the following:
- the lane-to-slice mapping between ports of different widths;
- old-data returns, both same-port and cross-port;
- that a narrow write leaves its neighbouring slices untouched;
- the absolute timing of reads in the registered variant.

// File: rtl/mtdp_pkg.sv
package mtdp_pkg;

    // Same-port read-during-write selection
    typedef enum logic {
        RDW_NEW = 1'b0,
        RDW_OLD = 1'b1
    } rdw_e;

endpackage

// File: rtl/mtdp_port_xlat.sv
module mtdp_port_xlat #(
    parameter int SLICE_W     = 8,
    parameter int WIDE_SLICES = 4,
    parameter int WIDE_DEPTH  = 64,
    parameter int RATIO       = 1,
    localparam int NARROW_W   = SLICE_W * RATIO,
    localparam int WIDE_W     = SLICE_W * WIDE_SLICES,
    localparam int ROW_W      = $clog2(WIDE_DEPTH),
    localparam int LANE_BITS  = $clog2(WIDE_SLICES / RATIO),
    localparam int ADDR_W     = ROW_W + LANE_BITS
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [NARROW_W-1:0]    wdata_i,
    input  logic [WIDE_W-1:0]      word_i,
    output logic [ROW_W-1:0]       row_o,
    output logic [WIDE_SLICES-1:0] mask_o,
    output logic [WIDE_W-1:0]      wide_o,
    output logic [NARROW_W-1:0]    narrow_o
);

    localparam logic [WIDE_SLICES-1:0] MASK_BASE = WIDE_SLICES'((1 << RATIO) - 1);

    generate
        if (LANE_BITS == 0) begin : g_full
            // Port is as wide as a row: no lane selection
            assign row_o    = addr_i;
            assign mask_o   = MASK_BASE;
            assign wide_o   = wdata_i;
            assign narrow_o = word_i;
        end else begin : g_lane
            logic [LANE_BITS-1:0] lane;
            assign lane     = addr_i[LANE_BITS-1:0];
            assign row_o    = addr_i[ADDR_W-1:LANE_BITS];
            // Lane 0 sits in the least significant slices
            assign mask_o   = MASK_BASE << (int'(lane) * RATIO);
            assign wide_o   = WIDE_W'(wdata_i) << (int'(lane) * NARROW_W);
            assign narrow_o = NARROW_W'(word_i >> (int'(lane) * NARROW_W));
        end
    endgenerate

endmodule

// File: rtl/mtdp_collide.sv
module mtdp_collide #(
    parameter int ROW_W       = 6,
    parameter int WIDE_SLICES = 4
) (
    input  logic                   we_a_i,
    input  logic                   we_b_i,
    input  logic [ROW_W-1:0]       row_a_i,
    input  logic [ROW_W-1:0]       row_b_i,
    input  logic [WIDE_SLICES-1:0] mask_a_i,
    input  logic [WIDE_SLICES-1:0] mask_b_i,
    output logic                   hit_o
);

    always_comb begin
        hit_o = we_a_i && we_b_i && (row_a_i == row_b_i) && (|(mask_a_i & mask_b_i));
    end

endmodule

// File: rtl/mtdp_out_pipe.sv
module mtdp_out_pipe #(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] stage_o,
    output logic [W-1:0] data_o
);

    logic [W-1:0] s1_d, s1_q;

    always_comb begin
        s1_d = s1_q;
        if (en_i) begin
            s1_d = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    assign stage_o = s1_q;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(s1_q)); // R4

    generate
        if (OUT_REG) begin : g_reg
            logic [W-1:0] s2_d, s2_q;

            always_comb begin
                s2_d = s1_q;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s2_q <= '0;
                end else begin
                    s2_q <= s2_d;
                end
            end

            assign data_o = s2_q;

            AST_EXTRA_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (data_o == $past(stage_o))); // R8
        end else begin : g_direct
            assign data_o = s1_q;
        end
    endgenerate

endmodule

// File: rtl/mtdp_ram.sv
module mtdp_ram #(
    parameter int             SLICE_W     = 8,
    parameter int             WIDE_SLICES = 4,
    parameter int             WIDE_DEPTH  = 64,
    parameter int             RATIO_A     = 1,
    parameter int             RATIO_B     = 4,
    parameter mtdp_pkg::rdw_e RDW_MODE    = mtdp_pkg::RDW_NEW,
    parameter bit             OUT_REG     = 1'b0,
    localparam int WIDE_W = SLICE_W * WIDE_SLICES,
    localparam int ROW_W  = $clog2(WIDE_DEPTH),
    localparam int DW_A   = SLICE_W * RATIO_A,
    localparam int DW_B   = SLICE_W * RATIO_B,
    localparam int AW_A   = ROW_W + $clog2(WIDE_SLICES / RATIO_A),
    localparam int AW_B   = ROW_W + $clog2(WIDE_SLICES / RATIO_B)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW_A-1:0] addr_a,
    input  logic [DW_A-1:0] wdata_a,
    input  logic            we_a,
    input  logic            re_a,
    output logic [DW_A-1:0] rdata_a,
    input  logic [AW_B-1:0] addr_b,
    input  logic [DW_B-1:0] wdata_b,
    input  logic            we_b,
    input  logic            re_b,
    output logic [DW_B-1:0] rdata_b,
    output logic            collision
);

    typedef struct packed {
        logic coll;
    } state_t;

    state_t st_d, st_q;

    logic [WIDE_W-1:0]      mem_q [WIDE_DEPTH];

    logic [ROW_W-1:0]       row_a, row_b;
    logic [WIDE_SLICES-1:0] mask_a, mask_b;
    logic [WIDE_W-1:0]      wide_a, wide_b;
    logic [WIDE_W-1:0]      word_a, word_b;
    logic [DW_A-1:0]        narrow_a, val_a, raw_a;
    logic [DW_B-1:0]        narrow_b, val_b, raw_b;
    logic                   hit;

    assign word_a = mem_q[row_a];
    assign word_b = mem_q[row_b];

    mtdp_port_xlat #(
        .SLICE_W(SLICE_W), .WIDE_SLICES(WIDE_SLICES),
        .WIDE_DEPTH(WIDE_DEPTH), .RATIO(RATIO_A)
    ) u_xlat_a (
        .addr_i(addr_a), .wdata_i(wdata_a), .word_i(word_a),
        .row_o(row_a), .mask_o(mask_a), .wide_o(wide_a), .narrow_o(narrow_a)
    );

    mtdp_port_xlat #(
        .SLICE_W(SLICE_W), .WIDE_SLICES(WIDE_SLICES),
        .WIDE_DEPTH(WIDE_DEPTH), .RATIO(RATIO_B)
    ) u_xlat_b (
        .addr_i(addr_b), .wdata_i(wdata_b), .word_i(word_b),
        .row_o(row_b), .mask_o(mask_b), .wide_o(wide_b), .narrow_o(narrow_b)
    );

    mtdp_collide #(
        .ROW_W(ROW_W), .WIDE_SLICES(WIDE_SLICES)
    ) u_collide (
        .we_a_i(we_a), .we_b_i(we_b), .row_a_i(row_a), .row_b_i(row_b),
        .mask_a_i(mask_a), .mask_b_i(mask_b), .hit_o(hit)
    );

    // Read value chosen per port; storage is sampled before this edge's writes
    always_comb begin
        val_a = narrow_a;
        val_b = narrow_b;
        if (RDW_MODE == mtdp_pkg::RDW_NEW) begin
            if (we_a) val_a = wdata_a;
            if (we_b) val_b = wdata_b;
        end
        st_d      = st_q;
        st_d.coll = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage: no reset; overlapping slices written by both ports go unknown
    always_ff @(posedge clk) begin
        for (int s = 0; s < WIDE_SLICES; s++) begin
            if (we_a && mask_a[s]) begin
                mem_q[row_a][s*SLICE_W +: SLICE_W] <= wide_a[s*SLICE_W +: SLICE_W];
            end
        end
        for (int s = 0; s < WIDE_SLICES; s++) begin
            if (we_b && mask_b[s]) begin
                if (we_a && mask_a[s] && (row_a == row_b)) begin
                    mem_q[row_b][s*SLICE_W +: SLICE_W] <= {SLICE_W{1'bx}};
                end else begin
                    mem_q[row_b][s*SLICE_W +: SLICE_W] <= wide_b[s*SLICE_W +: SLICE_W];
                end
            end
        end
    end

    mtdp_out_pipe #(.W(DW_A), .OUT_REG(OUT_REG)) u_pipe_a (
        .clk(clk), .rst_n(rst_n), .en_i(re_a), .val_i(val_a),
        .stage_o(raw_a), .data_o(rdata_a)
    );

    mtdp_out_pipe #(.W(DW_B), .OUT_REG(OUT_REG)) u_pipe_b (
        .clk(clk), .rst_n(rst_n), .en_i(re_b), .val_i(val_b),
        .stage_o(raw_b), .data_o(rdata_b)
    );

    assign collision = st_q.coll;

    AST_COLL_NEEDS_TWO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_a && we_b) |=> !collision); // R9

    AST_COLL_NEEDS_SAME_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (row_a != row_b) |=> !collision); // R9

    generate
        if (RDW_MODE == mtdp_pkg::RDW_NEW) begin : g_new_chk
            AST_NEW_DATA_A: assert property (@(posedge clk) disable iff (!rst_n)
                (we_a && re_a) |=> (raw_a == $past(wdata_a))); // R5
            AST_NEW_DATA_B: assert property (@(posedge clk) disable iff (!rst_n)
                (we_b && re_b) |=> (raw_b == $past(wdata_b))); // R5
        end
    endgenerate

endmodule

// File: tb/test_mtdp_ram.sv
module test_mtdp_ram;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Main instance: A x8 (8-bit addr), B x32 (6-bit addr), new data, no output register
    logic [7:0]  addr_a, wdata_a, rdata_a;
    logic [5:0]  addr_b;
    logic [31:0] wdata_b, rdata_b;
    logic        we_a, re_a, we_b, re_b, collision;

    mtdp_ram i_mtdp_ram (
        .clk(clk), .rst_n(rst_n),
        .addr_a(addr_a), .wdata_a(wdata_a), .we_a(we_a), .re_a(re_a), .rdata_a(rdata_a),
        .addr_b(addr_b), .wdata_b(wdata_b), .we_b(we_b), .re_b(re_b), .rdata_b(rdata_b),
        .collision(collision)
    );

    // Second instance: 9-bit slices, A x18, B x9, old data, output register
    logic [6:0]  x_addr_a;
    logic [17:0] x_wdata_a, x_rdata_a;
    logic [7:0]  x_addr_b;
    logic [8:0]  x_wdata_b, x_rdata_b;
    logic        x_we_a, x_re_a, x_we_b, x_re_b, x_coll;

    mtdp_ram #(
        .SLICE_W(9), .RATIO_A(2), .RATIO_B(1),
        .RDW_MODE(mtdp_pkg::RDW_OLD), .OUT_REG(1'b1)
    ) i_mtdp_ram_alt (
        .clk(clk), .rst_n(rst_n),
        .addr_a(x_addr_a), .wdata_a(x_wdata_a), .we_a(x_we_a), .re_a(x_re_a), .rdata_a(x_rdata_a),
        .addr_b(x_addr_b), .wdata_b(x_wdata_b), .we_b(x_we_b), .re_b(x_re_b), .rdata_b(x_rdata_b),
        .collision(x_coll)
    );

    typedef struct packed {
        logic        we_a;
        logic        re_a;
        logic [7:0]  ad_a;
        logic [7:0]  wd_a;
        logic        we_b;
        logic        re_b;
        logic [5:0]  ad_b;
        logic [31:0] wd_b;
        logic [7:0]  ex_a;
        logic [31:0] ex_b;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'h10, 8'h11, 1'b0, 1'b0, 6'h00, 32'h0,        8'h00, 32'h0,        4'd4},  // R4 outputs stay zero
        '{1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 6'h00, 32'h0,        8'h00, 32'h0,        4'd4},
        '{1'b1, 1'b0, 8'h12, 8'h33, 1'b0, 1'b0, 6'h00, 32'h0,        8'h00, 32'h0,        4'd4},
        '{1'b1, 1'b0, 8'h13, 8'h44, 1'b0, 1'b0, 6'h00, 32'h0,        8'h00, 32'h0,        4'd4},
        '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 6'h04, 32'h0,        8'h00, 32'h44332211, 4'd2},  // R2 lanes to slices
        '{1'b0, 1'b1, 8'h10, 8'h00, 1'b1, 1'b0, 6'h05, 32'hA1B2C3D4, 8'h11, 32'h44332211, 4'd3},  // R3
        '{1'b0, 1'b1, 8'h14, 8'h00, 1'b0, 1'b1, 6'h05, 32'h0,        8'hD4, 32'hA1B2C3D4, 4'd2},  // R2 wide to narrow
        '{1'b0, 1'b1, 8'h17, 8'h00, 1'b0, 1'b0, 6'h00, 32'h0,        8'hA1, 32'hA1B2C3D4, 4'd2},
        '{1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 6'h06, 32'hCAFEF00D, 8'hA1, 32'hCAFEF00D, 4'd5},  // R5 new data
        '{1'b1, 1'b0, 8'h18, 8'h55, 1'b0, 1'b1, 6'h06, 32'h0,        8'hA1, 32'hCAFEF00D, 4'd7},  // R7 cross-port old
        '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 6'h06, 32'h0,        8'hA1, 32'hCAFEF055, 4'd3},
        '{1'b1, 1'b0, 8'h19, 8'h66, 1'b0, 1'b0, 6'h00, 32'h0,        8'hA1, 32'hCAFEF055, 4'd4},  // R4 hold while writing
        '{1'b1, 1'b1, 8'h1A, 8'h77, 1'b0, 1'b0, 6'h00, 32'h0,        8'h77, 32'hCAFEF055, 4'd5},
        '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 6'h06, 32'h0,        8'h77, 32'hCA776655, 4'd11}  // R11 neighbours kept
    };

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_main();
        we_a = 1'b0; re_a = 1'b0; addr_a = '0; wdata_a = '0;
        we_b = 1'b0; re_b = 1'b0; addr_b = '0; wdata_b = '0;
    endtask

    task automatic idle_alt();
        x_we_a = 1'b0; x_re_a = 1'b0; x_addr_a = '0; x_wdata_a = '0;
        x_we_b = 1'b0; x_re_b = 1'b0; x_addr_b = '0; x_wdata_b = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle_main();
        idle_alt();
        repeat (3) @(negedge clk);
        // R1: values during reset
        check("R1 rdata_a", 36'(rdata_a), 36'h0);
        check("R1 rdata_b", 36'(rdata_b), 36'h0);
        check("R1 collision", 36'(collision), 36'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 alt rdata_a", 36'(x_rdata_a), 36'h0);
        check("R1 alt rdata_b", 36'(x_rdata_b), 36'h0);

        // Vector table on the main instance: drive, one edge, then compare
        for (int i = 0; i < NVEC; i++) begin
            we_a = VECS[i].we_a; re_a = VECS[i].re_a; addr_a = VECS[i].ad_a; wdata_a = VECS[i].wd_a;
            we_b = VECS[i].we_b; re_b = VECS[i].re_b; addr_b = VECS[i].ad_b; wdata_b = VECS[i].wd_b;
            @(negedge clk);
            check($sformatf("R%0d vec %0d port A", VECS[i].req, i), 36'(rdata_a), 36'(VECS[i].ex_a));
            check($sformatf("R%0d vec %0d port B", VECS[i].req, i), 36'(rdata_b), 36'(VECS[i].ex_b));
        end
        idle_main();

        // R9: overlapping writes to row 7
        we_a = 1'b1; addr_a = 8'h1C; wdata_a = 8'h12;
        we_b = 1'b1; addr_b = 6'h07; wdata_b = 32'h01020304;
        @(negedge clk);
        check("R9 overlap flag", 36'(collision), 36'h1);
        idle_main();
        @(negedge clk);
        check("R9 flag one cycle", 36'(collision), 36'h0);
        // R9: two writes to different rows
        we_a = 1'b1; addr_a = 8'h20; wdata_a = 8'h9A;
        we_b = 1'b1; addr_b = 6'h09; wdata_b = 32'h55AA55AA;
        @(negedge clk);
        check("R9 disjoint rows", 36'(collision), 36'h0);
        idle_main();
        @(negedge clk);

        // R10: 18-bit write at A address 3 -> row 1, slices 2 and 3 (B addresses 6, 7)
        x_we_a = 1'b1; x_addr_a = 7'd3; x_wdata_a = {9'h1AB, 9'h0CD};
        @(negedge clk);
        idle_alt();
        x_re_b = 1'b1; x_addr_b = 8'd6;
        @(negedge clk);
        x_re_b = 1'b0;
        check("R8 one cycle not yet", 36'(x_rdata_b), 36'h0);
        @(negedge clk);
        check("R10 low slice", 36'(x_rdata_b), 36'(9'h0CD));
        x_re_b = 1'b1; x_addr_b = 8'd7;
        @(negedge clk);
        x_re_b = 1'b0;
        @(negedge clk);
        check("R10 high slice", 36'(x_rdata_b), 36'(9'h1AB));

        // R6: old-data same-port read during write
        x_we_a = 1'b1; x_re_a = 1'b1; x_addr_a = 7'd3; x_wdata_a = {9'h011, 9'h022};
        @(negedge clk);
        idle_alt();
        check("R8 alt A still reset value", 36'(x_rdata_a), 36'h0);
        @(negedge clk);
        check("R6 old data", 36'(x_rdata_a), 36'({9'h1AB, 9'h0CD}));
        x_re_a = 1'b1; x_addr_a = 7'd3;
        @(negedge clk);
        x_re_a = 1'b0;
        check("R8 still previous", 36'(x_rdata_a), 36'({9'h1AB, 9'h0CD}));
        @(negedge clk);
        check("R6 write landed", 36'(x_rdata_a), 36'({9'h011, 9'h022}));
        @(negedge clk);
        check("R4 alt hold", 36'(x_rdata_a), 36'({9'h011, 9'h022}));

        summary();
    end

endmodule